// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block is the interrupt timer of a cartridge memory controller. It watches the processor's write port (address, data, strobe) and a one-cycle tick from the video side that arrives once per drawn line. Software programs a reload value and requests a reload. The next tick loads the counter. Each later tick counts it down. When the count reaches zero the block emits a one-cycle interrupt pulse and arms a fresh reload on its own, so the interval repeats without further writes.

The reload is lazy. A write does not touch the counter directly. It only marks a reload as pending, and that pending reload is consumed by the next tick. The tick that performs the reload never produces an interrupt. An enable flag gates the countdown. Writes to the upper address window clear or set this flag.

Top module: `line_irq_timer`

## Requirements
- R1: After reset the counter is 0, no reload is pending, counting is enabled and `irqPulse` is low, so ticks alone produce no interrupt.
- R2: A write whose address bits [15:13] are 3'b110 with address bit 0 clear stores `wrData` as the reload value.
- R3: Every write with address bits [15:13] equal to 3'b110 marks a reload as pending, whatever address bit 0 is. An odd-address write in that window leaves the reload value unchanged.
- R4: A write with address bits [15:13] equal to 3'b111 disables counting when address bit 0 is 0 and enables it when address bit 0 is 1.
- R5: A tick with a reload pending copies the reload value into the counter, clears the pending flag and raises no interrupt.
- R6: A tick with no reload pending, counting enabled and a nonzero counter decrements the counter. If the result is zero, an interrupt is raised and a reload becomes pending again.
- R7: A tick while the counter is zero, or while counting is disabled, changes nothing and raises no interrupt.
- R8: `irqPulse` is high for exactly one cycle, in the cycle after the clock edge that samples the tick that produced it.
- R9: When a write and a tick fall in the same cycle, the tick acts on the state from before the write, and the write takes effect afterwards.
- R10: Writes with address bits [15:13] outside 3'b110 and 3'b111 have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Processor write strobe, one cycle per write |
| wrAddr | input | 16 | Processor write address |
| wrData | input | 8 | Processor write data |
| lineTick | input | 1 | One-cycle pulse, once per scanline |
| irqPulse | output | 1 | One-cycle interrupt request |

## Verification
A register write and a line tick can fall in the same cycle. The two cases that matter most are a reload-window write arriving on the tick that consumes a pending reload, and an enable or disable write arriving on a decrementing tick. The bench provokes these cases with directed steps that assert `wrEn` and `lineTick` together. Random stimulus also makes them common. A bench model applies the tick to the old state first and the write second, and each collision step is judged by the interrupt pulse it produces and by the pulses on the ticks that follow.

// File: rtl/line_irq_pkg.sv
`timescale 1ns/1ps
package line_irq_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic latchWr;    // capture write data as reload value
    logic tickReload; // tick consumes a pending reload
    logic tickDec;    // tick decrements the counter
  } cnt_strobe_t;

  localparam int unsigned REGION_BITS = 3;
  localparam logic [REGION_BITS-1:0] RGN_RELOAD = 3'b110;
  localparam logic [REGION_BITS-1:0] RGN_ENABLE = 3'b111;
endpackage

// File: rtl/line_irq_ctrl.sv
`timescale 1ns/1ps
module line_irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              lineTick,
  input  logic              cntIsZero,
  input  logic              cntIsOne,
  output cnt_strobe_t       strobes,
  output logic              irqPulse
);
  localparam int unsigned RGN_MSB = ADDR_W - 1;

  logic [REGION_BITS-1:0] region;
  logic inReloadWin, inEnableWin, oddAddr;
  logic pendReload, enFlag, hitZero;

  assign region      = wrAddr[RGN_MSB -: REGION_BITS];
  assign oddAddr     = wrAddr[0];
  assign inReloadWin = wrEn && (region == RGN_RELOAD);
  assign inEnableWin = wrEn && (region == RGN_ENABLE);

  always_comb begin
    strobes            = '0;
    strobes.latchWr    = inReloadWin && !oddAddr;
    strobes.tickReload = lineTick && pendReload;
    strobes.tickDec    = lineTick && !pendReload && enFlag && !cntIsZero;
    hitZero            = strobes.tickDec && cntIsOne;
  end

  // Tick outcome first, write outcome overrides (write lands after the tick)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendReload <= 1'b0;
      enFlag     <= 1'b1;
      irqPulse   <= 1'b0;
    end else begin
      irqPulse <= hitZero;
      if (inReloadWin)             pendReload <= 1'b1;
      else if (hitZero)            pendReload <= 1'b1;
      else if (strobes.tickReload) pendReload <= 1'b0;
      if (inEnableWin)             enFlag <= oddAddr;
    end
  end

  p_reload_tick_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && pendReload) |=> !irqPulse);
  p_irq_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> pendReload);
  p_disable_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inEnableWin && !oddAddr) |=> !enFlag);
  p_enable_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inEnableWin && oddAddr) |=> enFlag);
  p_any_reload_write_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inReloadWin |=> pendReload);
  p_disabled_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && !enFlag) |=> !irqPulse);
endmodule

// File: rtl/line_irq_dpath.sv
`timescale 1ns/1ps
module line_irq_dpath
  import line_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wrData,
  input  cnt_strobe_t       strobes,
  output logic              cntIsZero,
  output logic              cntIsOne
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] reloadVal, count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloadVal <= '0;
      count     <= '0;
    end else begin
      if (strobes.latchWr)         reloadVal <= wrData;
      if (strobes.tickReload)      count <= reloadVal;
      else if (strobes.tickDec)    count <= count - ONE;
    end
  end

  assign cntIsZero = (count == '0);
  assign cntIsOne  = (count == ONE);

  p_tick_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.tickReload, strobes.tickDec}));
  p_reload_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.tickReload |=> (count == $past(reloadVal)));
  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.tickDec |=> (count == $past(count) - ONE));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.tickReload && !strobes.tickDec) |=> $stable(count));
endmodule

// File: rtl/line_irq_timer.sv
`timescale 1ns/1ps
module line_irq_timer
  import line_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lineTick,
  output logic              irqPulse
);
  cnt_strobe_t strobes;
  logic cntIsZero, cntIsOne;

  line_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .lineTick(lineTick), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne),
    .strobes(strobes), .irqPulse(irqPulse)
  );

  line_irq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .wrData(wrData), .strobes(strobes),
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne)
  );

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |=> !irqPulse);
  p_pulse_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> $past(lineTick));
endmodule

// File: tb/tb_line_irq_timer.sv
`timescale 1ns/1ps
module tb_line_irq_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic lineTick = 1'b0;
  logic irqPulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  logic [7:0] mLatch, mCnt;
  bit mPend, mEn;

  always #2.5 clk = ~clk;

  line_irq_timer dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .lineTick(lineTick), .irqPulse(irqPulse)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s irqPulse actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected irq from the requirements: tick on old state, then the write
  function automatic bit model_step(input bit w, input logic [15:0] a,
                                    input logic [7:0] d, input bit t,
                                    output string tag);
    bit irq = 0;
    tag = "R8";
    if (t) begin
      if (mPend) begin mCnt = mLatch; mPend = 0; tag = "R5"; end
      else if (mEn && mCnt != 0) begin
        mCnt = mCnt - 8'd1; tag = "R6";
        if (mCnt == 0) begin irq = 1; mPend = 1; end
      end else tag = "R7";
    end
    if (w && t) tag = "R9";
    if (w && a[15:13] == 3'b110) begin
      if (!a[0]) mLatch = d;
      mPend = 1;
    end
    if (w && a[15:13] == 3'b111) mEn = a[0];
    return irq;
  endfunction

  // Called at a falling edge: drive, pass one rising edge, sample at next fall
  task automatic step(input bit w, input logic [15:0] a, input logic [7:0] d,
                      input bit t, input string why);
    string tag;
    bit expIrq;
    wrEn = w; wrAddr = a; wrData = d; lineTick = t;
    expIrq = model_step(w, a, d, t, tag);
    if (why != "") tag = why;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; lineTick = 0;
    check(irqPulse, expIrq, tag);
  endtask

  task automatic ticks(input int n, input string why);
    for (int i = 0; i < n; i++) step(0, 16'h0000, 8'h00, 1, why);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    mLatch = 0; mCnt = 0; mPend = 0; mEn = 1;
    repeat (3) @(negedge clk);
    check(irqPulse, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(irqPulse, 1'b0, "R1");
    ticks(4, "R1");                      // counter 0: no irq
    // enabled out of reset, latch 2, reload then two decrements
    step(1, 16'hC000, 8'd2, 0, "R2");
    step(0, 16'h0, 8'h0, 1, "R5");       // reload tick, quiet
    step(0, 16'h0, 8'h0, 1, "R6");       // 2 -> 1
    step(0, 16'h0, 8'h0, 1, "R6");       // 1 -> 0, irq
    step(0, 16'h0, 8'h0, 0, "R8");       // pulse gone
    step(0, 16'h0, 8'h0, 1, "R5");       // automatic re-arm reload
    ticks(2, "R6");                      // irq again after 2
    // odd reload-window write: pending only, latch stays 2
    step(1, 16'hC001, 8'd9, 0, "R3");
    ticks(3, "R3");                      // reload, 1, irq
    // disable blocks countdown
    step(1, 16'hE000, 8'h00, 0, "R4");
    ticks(5, "R4");                      // reload then nothing
    step(1, 16'hFFFF, 8'h00, 0, "R4");   // odd: enable
    ticks(2, "R4");
    // writes outside the windows are ignored
    step(1, 16'h8000, 8'd1, 0, "R10");
    step(1, 16'hA001, 8'd1, 0, "R10");
    step(1, 16'h6000, 8'd1, 0, "R10");
    ticks(3, "R10");                     // reload of 2, then irq
    // same-cycle: reload tick with new latch write -> old latch loaded
    step(1, 16'hC000, 8'd1, 0, "R9");
    step(1, 16'hC002, 8'd3, 1, "R9");    // loads 1, new pending, latch 3
    step(0, 16'h0, 8'h0, 1, "R9");       // reload 3, quiet
    step(1, 16'hE000, 8'h0, 1, "R9");    // decrement on old enable
    step(1, 16'hE001, 8'h0, 1, "R9");    // disabled: no change
    ticks(2, "R9");                      // 2 -> 1 -> 0 irq
    // latch zero: reload to 0 then stays quiet
    step(1, 16'hC000, 8'd0, 0, "R7");
    ticks(4, "R7");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      bit w, t;
      case ($urandom % 6)
        0, 1: a = {3'b110, 13'($urandom)};
        2, 3: a = {3'b111, 13'($urandom)};
        default: a = 16'($urandom);
      endcase
      w = (($urandom % 3) == 0);
      t = (($urandom % 2) == 0);
      step(w, a, 8'($urandom % 5), t, "");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule